// File: doc/BRIEF.md
# MSI Remap Table Translator

This block turns an incoming message-signalled interrupt into a delivery request for a CPU. The data field of the MSI write is an index into a remap table held in memory. Each 16-byte table entry does not name a target; it holds a valid flag and a pointer to a 64-byte posting record. The block reads the entry, rebuilds the record address from the pointer, reads the record's control word and then either raises a delivery request with the record's destination CPU and vector number, or reports the request as pending when the record's doorbell enable is clear.

Entry reads go through a small direct-mapped cache of valid entries, so a repeated MSI to the same index costs only the record fetch. Software edits to the table are made visible by an invalidate-by-index strobe from the invalidation queue, which is acknowledged one cycle later. An MSI that lands on an invalid entry is dropped and counted in a fault counter. One translation is in flight at a time; the memory read port carries one 64-bit word per request.

Top module: `msirt_xlate`

## Requirements
- R1: After reset, `dlv_valid_o`, `pend_valid_o`, `mem_req_o` and `inv_ack_o` are low, `fault_cnt_o` is zero and `msi_ready_o` is high.
- R2: An entry fetch reads address `tbl_base_i + index*16`; a record fetch reads address `(ptr << 6) + 32`, where `ptr` is entry bits 47:6. `mem_req_o` stays high with a stable `mem_addr_o` until the cycle `mem_rvalid_i` is seen.
- R3: For a valid entry (entry bit 0 set) whose record word has bit 0 (doorbell enable) set, a single-cycle `dlv_valid_o` is raised with `dlv_cpu_o` = record word bits 63:32 (byte 36), `dlv_vec_o` = bits 15:8 (byte 33) and `dlv_index_o` = the MSI index.
- R4: When the doorbell enable is clear, a single-cycle `pend_valid_o` is raised with `pend_index_o` = the MSI index and no delivery is raised.
- R5: An MSI whose entry has bit 0 clear is dropped: no record fetch, no delivery, no pending report, `fault_cnt_o` increases by exactly one, and the entry is not cached.
- R6: A repeated MSI to an index whose valid entry is cached issues only the record fetch.
- R7: `inv_ack_o` is high exactly one cycle after each `inv_valid_i` cycle; after an invalidate of an index, the next MSI to it re-fetches the entry and uses the new table content. An invalidate of another index leaves a cached entry in place.
- R8: An invalidate of the index whose entry fetch is in flight prevents that entry from being cached; the MSI itself still completes.
- R9: `msi_ready_o` is low from the cycle after an MSI is accepted until its translation ends; `mem_req_o` is never high while `msi_ready_o` is high.
- R10: The cache is direct-mapped on index bits 2:0 (8 sets by default); two indices sharing those bits evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tbl_base_i | input | AW | Physical base of the remap table |
| msi_valid_i | input | 1 | MSI write present |
| msi_index_i | input | IDX_W | MSI data field: table index |
| msi_ready_o | output | 1 | MSI accepted this cycle when high |
| inv_valid_i | input | 1 | Invalidate-by-index strobe |
| inv_index_i | input | IDX_W | Index to invalidate |
| inv_ack_o | output | 1 | Invalidate acknowledge, one cycle after the strobe |
| mem_req_o | output | 1 | Memory read request, held until response |
| mem_addr_o | output | AW | Byte address of the 64-bit word to read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data word |
| dlv_valid_o | output | 1 | Delivery request pulse |
| dlv_index_o | output | IDX_W | Index of the delivered MSI |
| dlv_cpu_o | output | 32 | Destination CPU from the record |
| dlv_vec_o | output | 8 | Vector number from the record |
| pend_valid_o | output | 1 | Pending report pulse (doorbell disabled) |
| pend_index_o | output | IDX_W | Index of the pending MSI |
| fault_cnt_o | output | CNT_W | Count of MSIs dropped on invalid entries |

## Verification
The checker watches on every cycle that the read request holds its address until answered, that the invalidate acknowledge follows each strobe by exactly one cycle, that delivery and pending pulses are single-cycle and never coincide, that no request is issued while the block reports ready, and that the fault counter moves by at most one. Whether a repeated MSI hits the cache, whether an invalidate really forces a re-fetch, the race between an invalidate and an in-flight entry fill, set conflicts, and the decoded CPU and vector values only show in the bench's scenarios, which count the entry and record reads per MSI and compare the outputs with values derived from the table contents.

// File: rtl/msirt_pkg.sv
package msirt_pkg;
  // entry low word fields
  localparam int unsigned ENT_VLD_BIT = 0;
  localparam int unsigned ENT_PTR_LO  = 6;
  // record control word, read at record byte offset 32
  localparam int unsigned REC_OFS     = 32;
  localparam int unsigned REC_DB_BIT  = 0;
  localparam int unsigned REC_VEC_LO  = 8;
  localparam int unsigned REC_CPU_LO  = 32;
  localparam int unsigned ENT_SHIFT   = 4;  // 16-byte entries

  typedef enum logic [1:0] {ST_IDLE, ST_ENT, ST_REC} walk_st_e;
endpackage

// File: rtl/msirt_cache.sv
module msirt_cache #(
  parameter int unsigned IDX_W = 16,
  parameter int unsigned SET_W = 3,
  parameter int unsigned PTR_W = 42
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  output logic             lk_hit_o,
  output logic [PTR_W-1:0] lk_ptr_o,
  input  logic             fill_en_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [PTR_W-1:0] fill_ptr_i,
  input  logic             inv_en_i,
  input  logic [IDX_W-1:0] inv_idx_i
);
  localparam int unsigned SETS  = 1 << SET_W;
  localparam int unsigned TAG_W = IDX_W - SET_W;

  logic [SETS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [PTR_W-1:0] ptr_q [SETS];

  logic [SET_W-1:0] lk_set;
  assign lk_set   = lk_idx_i[SET_W-1:0];
  // an invalidate in the same cycle masks the hit
  assign lk_hit_o = vld_q[lk_set] && (tag_q[lk_set] == lk_idx_i[IDX_W-1:SET_W])
                    && !(inv_en_i && inv_idx_i == lk_idx_i);
  assign lk_ptr_o = ptr_q[lk_set];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic fill_sel, inv_sel;
    assign fill_sel = fill_en_i && (fill_idx_i[SET_W-1:0] == SET_W'(s));
    assign inv_sel  = inv_en_i && (inv_idx_i[SET_W-1:0] == SET_W'(s))
                      && (tag_q[s] == inv_idx_i[IDX_W-1:SET_W]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s] <= 1'b0;
        tag_q[s] <= '0;
        ptr_q[s] <= '0;
      end else if (fill_sel) begin
        vld_q[s] <= 1'b1;
        tag_q[s] <= fill_idx_i[IDX_W-1:SET_W];
        ptr_q[s] <= fill_ptr_i;
      end else if (inv_sel) begin
        vld_q[s] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/msirt_walk.sv
module msirt_walk
  import msirt_pkg::*;
#(
  parameter int unsigned IDX_W = 16,
  parameter int unsigned AW    = 48,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned PTR_W = AW - 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    tbl_base_i,
  input  logic             msi_valid_i,
  input  logic [IDX_W-1:0] msi_index_i,
  output logic             msi_ready_o,
  input  logic             inv_valid_i,
  input  logic [IDX_W-1:0] inv_index_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [63:0]      mem_rdata_i,
  input  logic             lk_hit_i,
  input  logic [PTR_W-1:0] lk_ptr_i,
  output logic             fill_en_o,
  output logic [IDX_W-1:0] fill_idx_o,
  output logic [PTR_W-1:0] fill_ptr_o,
  output logic             dlv_valid_o,
  output logic [IDX_W-1:0] dlv_index_o,
  output logic [31:0]      dlv_cpu_o,
  output logic [7:0]       dlv_vec_o,
  output logic             pend_valid_o,
  output logic [IDX_W-1:0] pend_index_o,
  output logic [CNT_W-1:0] fault_cnt_o
);
  walk_st_e         st_q;
  logic [IDX_W-1:0] idx_q;
  logic [PTR_W-1:0] ptr_q;
  logic             kill_q;
  logic             inv_same, ent_ok;

  assign inv_same    = inv_valid_i && (inv_index_i == idx_q);
  assign ent_ok      = mem_rdata_i[ENT_VLD_BIT];
  assign msi_ready_o = (st_q == ST_IDLE);
  assign mem_req_o   = (st_q != ST_IDLE);
  assign mem_addr_o  = (st_q == ST_ENT)
                       ? tbl_base_i + {{(AW-IDX_W-ENT_SHIFT){1'b0}}, idx_q, {ENT_SHIFT{1'b0}}}
                       : {ptr_q, 6'b0} + AW'(REC_OFS);

  // fill suppressed if this index was invalidated while its fetch was in flight
  assign fill_en_o  = (st_q == ST_ENT) && mem_rvalid_i && ent_ok && !kill_q && !inv_same;
  assign fill_idx_o = idx_q;
  assign fill_ptr_o = mem_rdata_i[ENT_PTR_LO +: PTR_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      idx_q        <= '0;
      ptr_q        <= '0;
      kill_q       <= 1'b0;
      dlv_valid_o  <= 1'b0;
      dlv_index_o  <= '0;
      dlv_cpu_o    <= '0;
      dlv_vec_o    <= '0;
      pend_valid_o <= 1'b0;
      pend_index_o <= '0;
      fault_cnt_o  <= '0;
    end else begin
      dlv_valid_o  <= 1'b0;
      pend_valid_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (msi_valid_i) begin
          idx_q  <= msi_index_i;
          kill_q <= 1'b0;
          if (lk_hit_i) begin
            ptr_q <= lk_ptr_i;
            st_q  <= ST_REC;
          end else begin
            st_q  <= ST_ENT;
          end
        end
        ST_ENT: begin
          if (inv_same) kill_q <= 1'b1;
          if (mem_rvalid_i) begin
            if (ent_ok) begin
              ptr_q <= mem_rdata_i[ENT_PTR_LO +: PTR_W];
              st_q  <= ST_REC;
            end else begin
              fault_cnt_o <= fault_cnt_o + 1'b1;
              st_q        <= ST_IDLE;
            end
          end
        end
        ST_REC: if (mem_rvalid_i) begin
          if (mem_rdata_i[REC_DB_BIT]) begin
            dlv_valid_o <= 1'b1;
            dlv_index_o <= idx_q;
            dlv_cpu_o   <= mem_rdata_i[REC_CPU_LO +: 32];
            dlv_vec_o   <= mem_rdata_i[REC_VEC_LO +: 8];
          end else begin
            pend_valid_o <= 1'b1;
            pend_index_o <= idx_q;
          end
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msirt_xlate.sv
module msirt_xlate #(
  parameter int unsigned IDX_W = 16,
  parameter int unsigned SET_W = 3,
  parameter int unsigned AW    = 48,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    tbl_base_i,
  input  logic             msi_valid_i,
  input  logic [IDX_W-1:0] msi_index_i,
  output logic             msi_ready_o,
  input  logic             inv_valid_i,
  input  logic [IDX_W-1:0] inv_index_i,
  output logic             inv_ack_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [63:0]      mem_rdata_i,
  output logic             dlv_valid_o,
  output logic [IDX_W-1:0] dlv_index_o,
  output logic [31:0]      dlv_cpu_o,
  output logic [7:0]       dlv_vec_o,
  output logic             pend_valid_o,
  output logic [IDX_W-1:0] pend_index_o,
  output logic [CNT_W-1:0] fault_cnt_o
);
  localparam int unsigned PTR_W = AW - 6;

  logic             lk_hit, fill_en;
  logic [PTR_W-1:0] lk_ptr, fill_ptr;
  logic [IDX_W-1:0] fill_idx;

  msirt_cache #(.IDX_W(IDX_W), .SET_W(SET_W), .PTR_W(PTR_W)) u_cache (
    .clk_i, .rst_ni,
    .lk_idx_i  (msi_index_i),
    .lk_hit_o  (lk_hit),
    .lk_ptr_o  (lk_ptr),
    .fill_en_i (fill_en),
    .fill_idx_i(fill_idx),
    .fill_ptr_i(fill_ptr),
    .inv_en_i  (inv_valid_i),
    .inv_idx_i (inv_index_i)
  );

  msirt_walk #(.IDX_W(IDX_W), .AW(AW), .CNT_W(CNT_W)) u_walk (
    .clk_i, .rst_ni, .tbl_base_i,
    .msi_valid_i, .msi_index_i, .msi_ready_o,
    .inv_valid_i, .inv_index_i,
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .lk_hit_i  (lk_hit),
    .lk_ptr_i  (lk_ptr),
    .fill_en_o (fill_en),
    .fill_idx_o(fill_idx),
    .fill_ptr_o(fill_ptr),
    .dlv_valid_o, .dlv_index_o, .dlv_cpu_o, .dlv_vec_o,
    .pend_valid_o, .pend_index_o, .fault_cnt_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inv_ack_o <= 1'b0;
    else         inv_ack_o <= inv_valid_i;
  end
endmodule

// File: rtl/msirt_xlate_chk.sv
module msirt_xlate_chk #(
  parameter int unsigned AW    = 48,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             msi_valid_i,
  input logic             msi_ready_o,
  input logic             inv_valid_i,
  input logic             inv_ack_o,
  input logic             mem_req_o,
  input logic [AW-1:0]    mem_addr_o,
  input logic             mem_rvalid_i,
  input logic             dlv_valid_o,
  input logic             pend_valid_o,
  input logic [CNT_W-1:0] fault_cnt_o
);
  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

  assert_single_dlv_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_o |=> !dlv_valid_o);

  assert_excl_out_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dlv_valid_o && pend_valid_o));

  assert_fault_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (fault_cnt_o == $past(fault_cnt_o)) || (fault_cnt_o == $past(fault_cnt_o) + CNT_W'(1)));

  assert_ack_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_i |=> inv_ack_o);

  assert_ack_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inv_valid_i |=> !inv_ack_o);

  assert_busy_after_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_valid_i && msi_ready_o |=> !msi_ready_o);

  assert_no_req_when_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && msi_ready_o));
endmodule

bind msirt_xlate msirt_xlate_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .msi_valid_i(msi_valid_i), .msi_ready_o(msi_ready_o),
  .inv_valid_i(inv_valid_i), .inv_ack_o(inv_ack_o), .mem_req_o(mem_req_o),
  .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i), .dlv_valid_o(dlv_valid_o),
  .pend_valid_o(pend_valid_o), .fault_cnt_o(fault_cnt_o)
);

// File: tb/msirt_xlate_tb.sv
module msirt_xlate_tb;
  localparam int unsigned IDX_W = 16;
  localparam int unsigned AW    = 48;
  localparam int unsigned CNT_W = 16;
  localparam logic [AW-1:0] BASE = 48'h0000_4000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             msi_valid = 0, inv_valid = 0;
  logic [IDX_W-1:0] msi_index = '0, inv_index = '0;
  logic             msi_ready, inv_ack, mem_req, mem_rvalid, dlv_valid, pend_valid;
  logic [AW-1:0]    mem_addr;
  logic [63:0]      mem_rdata;
  logic [IDX_W-1:0] dlv_index, pend_index;
  logic [31:0]      dlv_cpu;
  logic [7:0]       dlv_vec;
  logic [CNT_W-1:0] fault_cnt;

  msirt_xlate u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tbl_base_i(BASE),
    .msi_valid_i(msi_valid), .msi_index_i(msi_index), .msi_ready_o(msi_ready),
    .inv_valid_i(inv_valid), .inv_index_i(inv_index), .inv_ack_o(inv_ack),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .dlv_valid_o(dlv_valid), .dlv_index_o(dlv_index), .dlv_cpu_o(dlv_cpu), .dlv_vec_o(dlv_vec),
    .pend_valid_o(pend_valid), .pend_index_o(pend_index), .fault_cnt_o(fault_cnt)
  );

  int nvec = 0, nfail = 0;
  int gen [int];
  int mem_lat = 1;

  function automatic int gen_of(int i);
    return gen.exists(i) ? gen[i] : 0;
  endfunction
  function automatic bit ent_vld(int i, int g);
    return ((i * 7 + g) % 4) != 0;
  endfunction
  function automatic logic [41:0] ent_ptr(int i, int g);
    return {12'hABC, g[13:0], i[15:0]};
  endfunction
  function automatic bit db_of(logic [41:0] p);
    return ((int'(p[15:0]) + int'(p[29:16])) % 3) != 0;
  endfunction
  function automatic logic [31:0] cpu_of(logic [41:0] p);
    return {p[15:0], 2'b01, p[29:16]};
  endfunction
  function automatic logic [7:0] vec_of(logic [41:0] p);
    return p[7:0] ^ 8'h3c;
  endfunction

  // memory model: entries inside the table window, records elsewhere
  int n_ent = 0, n_rec = 0, lat_cnt = 0;
  logic [AW-1:0] last_ent, last_rec;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0; mem_rdata <= '0; lat_cnt <= 0;
    end else if (mem_rvalid) begin
      mem_rvalid <= 1'b0; lat_cnt <= 0;
    end else if (mem_req) begin
      if (lat_cnt >= mem_lat) begin
        mem_rvalid <= 1'b1;
        if (mem_addr >= BASE && mem_addr < BASE + 48'h10_0000) begin
          int i, g;
          i = int'((mem_addr - BASE) >> 4);
          g = gen_of(i);
          mem_rdata <= {8'hff, 8'h00, ent_ptr(i, g), 5'b0, ent_vld(i, g)};
          n_ent++; last_ent = mem_addr;
        end else begin
          logic [41:0] p;
          p = mem_addr[47:6];
          mem_rdata <= {cpu_of(p), 16'h0, vec_of(p), 7'h0, db_of(p)};
          n_rec++; last_rec = mem_addr;
        end
      end else lat_cnt <= lat_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  int exp_fault = 0;

  task automatic run_msi(input int idx, input bit inv_mid, output int ents);
    int ne0, nr0, g;
    bit got_d, got_p;
    logic [31:0] c; logic [7:0] v; logic [IDX_W-1:0] di, pi;
    logic [41:0] p;
    got_d = 0; got_p = 0; c = '0; v = '0; di = '0; pi = '0;
    while (!msi_ready) @(negedge clk);
    ne0 = n_ent; nr0 = n_rec;
    msi_valid = 1; msi_index = idx[IDX_W-1:0];
    @(negedge clk);
    msi_valid = 0;
    chk(!msi_ready, "R9", "ready after accept", 64'(msi_ready), 64'd0);
    if (inv_mid) begin
      inv_valid = 1; inv_index = idx[IDX_W-1:0];
      @(negedge clk);
      inv_valid = 0;
    end
    for (int k = 0; k < 200; k++) begin
      if (dlv_valid) begin got_d = 1; c = dlv_cpu; v = dlv_vec; di = dlv_index; end
      if (pend_valid) begin got_p = 1; pi = pend_index; end
      if (msi_ready) break;
      @(negedge clk);
    end
    ents = n_ent - ne0;
    g = gen_of(idx);
    if (ents == 1)
      chk(last_ent == BASE + AW'(idx) * 16, "R2", "entry address", 64'(last_ent), 64'(BASE + AW'(idx) * 16));
    if (!ent_vld(idx, g)) begin
      exp_fault++;
      chk(!got_d && !got_p && (n_rec == nr0), "R5", "dropped msi", {got_d, got_p, 30'(n_rec - nr0)}, 0);
      chk(int'(fault_cnt) == exp_fault, "R5", "fault count", 64'(fault_cnt), 64'(exp_fault));
    end else begin
      p = ent_ptr(idx, g);
      chk(n_rec - nr0 == 1, "R2", "record fetches", 64'(n_rec - nr0), 64'd1);
      chk(last_rec == {p, 6'b0} + 48'd32, "R2", "record address", 64'(last_rec), 64'({p, 6'b0} + 48'd32));
      if (db_of(p)) begin
        chk(got_d && !got_p, "R3", "delivery raised", {got_d, got_p}, 2'b10);
        chk(c == cpu_of(p), "R3", "dest cpu", 64'(c), 64'(cpu_of(p)));
        chk(v == vec_of(p), "R3", "vector", 64'(v), 64'(vec_of(p)));
        chk(int'(di) == idx, "R3", "delivery index", 64'(di), 64'(idx));
      end else begin
        chk(got_p && !got_d, "R4", "pending only", {got_d, got_p}, 2'b01);
        chk(int'(pi) == idx, "R4", "pending index", 64'(pi), 64'(idx));
      end
      chk(int'(fault_cnt) == exp_fault, "R5", "fault unchanged", 64'(fault_cnt), 64'(exp_fault));
    end
  endtask

  task automatic do_inv(input int idx);
    @(negedge clk);
    inv_valid = 1; inv_index = idx[IDX_W-1:0];
    @(negedge clk);
    inv_valid = 0;
    chk(inv_ack, "R7", "ack one cycle later", 64'(inv_ack), 64'd1);
    @(negedge clk);
    chk(!inv_ack, "R7", "ack single cycle", 64'(inv_ack), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int e;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(!dlv_valid && !pend_valid && !mem_req && !inv_ack, "R1", "outputs idle in reset",
        {dlv_valid, pend_valid, mem_req, inv_ack}, 0);
    chk(fault_cnt == 0 && msi_ready, "R1", "fault zero, ready", {fault_cnt, msi_ready}, 1);
    rst_n = 1;
    @(negedge clk);

    // invalid entry (index 4), dropped twice and never cached
    run_msi(4, 0, e); chk(e == 1, "R5", "invalid entry fetched", e, 1);
    run_msi(4, 0, e); chk(e == 1, "R5", "invalid entry not cached", e, 1);
    // delivery (1, 2) and pending (3), with cache hits on repeats
    run_msi(1, 0, e); chk(e == 1, "R6", "first fetch", e, 1);
    run_msi(1, 0, e); chk(e == 0, "R6", "repeat hits cache", e, 0);
    run_msi(2, 0, e);
    run_msi(3, 0, e);
    run_msi(3, 0, e); chk(e == 0, "R6", "pending entry cached", e, 0);
    // invalidate after table edit: index 1 becomes invalid
    gen[1] = 1;
    do_inv(1);
    run_msi(1, 0, e); chk(e == 1, "R7", "refetch after invalidate", e, 1);
    // unrelated invalidate leaves index 2 cached
    run_msi(2, 0, e);
    do_inv(13);
    run_msi(2, 0, e); chk(e == 0, "R7", "other index still cached", e, 0);
    // set conflict: 2 and 10 share index bits 2:0
    run_msi(10, 0, e); chk(e == 1, "R10", "conflict miss", e, 1);
    run_msi(2, 0, e);  chk(e == 1, "R10", "evicted by conflict", e, 1);
    // invalidate during the entry fetch
    mem_lat = 6;
    run_msi(5, 1, e); chk(e == 1, "R8", "racing msi fetched", e, 1);
    mem_lat = 1;
    run_msi(5, 0, e); chk(e == 1, "R8", "not cached after race", e, 1);
    run_msi(5, 0, e); chk(e == 0, "R8", "cached afterwards", e, 0);

    // random phase
    for (int n = 0; n < 300; n++) begin
      int idx;
      mem_lat = $urandom_range(0, 3);
      idx = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 65535)) : int'($urandom_range(0, 23));
      if (n % 8 == 7) begin
        int j;
        j = $urandom_range(0, 23);
        gen[j] = gen_of(j) + 1;
        do_inv(j);
      end
      run_msi(idx, 0, e);
      chk(e <= 1, "R6", "at most one entry fetch", e, 1);
    end

    repeat (4) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule